// File: doc/BRIEF.md
# Fine-Adjust PWM D/A Channel

This block is one channel of a pulse-width D/A converter. A free-running counter advances once per resolution tick and is split into a short repeating base cycle and a base-cycle index. Within every base cycle the upper bits of the data value set a main pulse width. The low bits of the data value decide which base cycles receive one extra pulse that is a single tick wide. Those extra ticks are scattered as evenly as possible over the full conversion period. After an external low-pass filter, the mean output level resolves the full data width. The base cycle is short, which keeps the ripple low.

Software writes a single register that holds the data value, a carrier select bit and a reserved bit. The channel uses a new value only from the start of the next conversion period, so no period ever mixes two values. When the data value lies outside the legal range for the chosen carrier, the output stays low.

Top module: `pwmfa_channel`

## Requirements
- R1: The register is REG_W = CNT_W+2 bits wide. Bits REG_W-1..2 hold the data value, bit 1 is the carrier select (0 = narrow, 1 = wide) and bit 0 is reserved. A write takes effect at the next clock edge. A read returns the written bits 15..1 and always returns 1 in bit 0.
- R2: Reset sets every register bit to 1, clears the counter to 0 and drives the output low.
- R3: The counter and the output change only on cycles where the tick enable is high. The counter steps by one per tick and wraps after 2^CNT_W ticks, which is one conversion period.
- R4: A base cycle lasts 2^NARROW_B ticks (64 by default) with select 0, and 2^WIDE_B ticks (256 by default) with select 1.
- R5: Let B be the base-cycle bit count of the active carrier. The main width c is the upper B bits of the data value. At base-cycle position p the output is high when p < c. The output follows the counter value of each tick one clock later.
- R6: The low CNT_W-B data bits form the fine value f. At position p = c in base cycle k, the output is high for one tick when the bit-reversed k is less than f. As a result, every base cycle holds either c or c+1 high ticks.
- R7: For a legal value, the number of high ticks in one conversion period equals the data value.
- R8: A value is legal when its main width c is nonzero. With the defaults, legal register values are 0x0401 to 0xFFFD for select 0 and 0x0103 to 0xFFFF for select 1. For an illegal value the output stays low for the whole period.
- R9: A written value becomes active only at the tick that wraps the counter. A write in mid-period leaves the current period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Resolution tick enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | REG_W | Register write value |
| rd_data_o | output | REG_W | Register read value |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the channel with CNT_W = 10 and keeps the base-cycle widths at 6 and 8 bits. This gives a 1024-tick conversion period with 4-bit and 2-bit fine fields. Many full periods then fit in a short run, so every period end can be compared against its exact high-tick count and every base cycle against its c or c+1 bound. At this width the range edges are 16 for the narrow carrier and 4 for the wide one, and both sides of each edge are reached.

// File: rtl/pwmfa_pkg.sv
package pwmfa_pkg;
  typedef enum logic {
    CARRIER_NARROW = 1'b0,
    CARRIER_WIDE   = 1'b1
  } carrier_e;
endpackage

// File: rtl/pwmfa_regs.sv
module pwmfa_regs
  import pwmfa_pkg::*;
#(
  parameter int CNT_W = 14,
  localparam int REG_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wrap,
  output logic [CNT_W-1:0] host_data,
  output carrier_e         host_sel,
  output logic [CNT_W-1:0] act_data,
  output carrier_e         act_sel
);
  // host copy: visible to software at once
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_data <= '1;
      host_sel  <= CARRIER_WIDE;
    end else if (wr_en) begin
      host_data <= wr_data[REG_W-1:2];
      host_sel  <= carrier_e'(wr_data[1]);
    end
  end

  // active copy: loaded only when the period wraps
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_data <= '1;
      act_sel  <= CARRIER_WIDE;
    end else if (wrap) begin
      act_data <= host_data;
      act_sel  <= host_sel;
    end
  end
endmodule

// File: rtl/pwmfa_counter.sv
module pwmfa_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  assign wrap = tick && (&cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwmfa_compare.sv
module pwmfa_compare
  import pwmfa_pkg::*;
#(
  parameter int CNT_W    = 14,
  parameter int NARROW_B = 6,
  parameter int WIDE_B   = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] data_i,
  input  carrier_e         sel_i,
  output logic             coarse_hit,
  output logic             fine_hit,
  output logic             range_ok,
  output logic             level
);
  logic [1:0] c_hit_v, f_hit_v, ok_v;

  for (genvar m = 0; m < 2; m++) begin : g_mode
    localparam int B  = (m == 1) ? WIDE_B : NARROW_B;
    localparam int FW = CNT_W - B;
    logic [B-1:0]  pos, crs;
    logic [FW-1:0] idx, idx_rev, fin;

    assign pos = cnt_i[B-1:0];
    assign idx = cnt_i[CNT_W-1:B];
    assign crs = data_i[CNT_W-1:FW];
    assign fin = data_i[FW-1:0];

    // the lowest fine bit is weighed against the highest index bit
    for (genvar k = 0; k < FW; k++) begin : g_rev
      assign idx_rev[k] = idx[FW-1-k];
    end

    assign c_hit_v[m] = pos < crs;
    assign f_hit_v[m] = (pos == crs) && (idx_rev < fin);
    assign ok_v[m]    = crs != '0;
  end

  assign coarse_hit = c_hit_v[sel_i];
  assign fine_hit   = f_hit_v[sel_i];
  assign range_ok   = ok_v[sel_i];
  assign level      = range_ok && (coarse_hit || fine_hit);
endmodule

// File: rtl/pwmfa_channel.sv
module pwmfa_channel
  import pwmfa_pkg::*;
#(
  parameter int CNT_W    = 14,
  parameter int NARROW_B = 6,
  parameter int WIDE_B   = 8,
  localparam int REG_W   = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;
  logic [CNT_W-1:0] host_data, act_data;
  carrier_e         host_sel, act_sel;
  logic             coarse_hit, fine_hit, range_ok, level;

  pwmfa_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .cnt_q(cnt_q), .wrap(wrap)
  );

  pwmfa_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_data(wr_data_i),
    .wrap(wrap), .host_data(host_data), .host_sel(host_sel),
    .act_data(act_data), .act_sel(act_sel)
  );

  pwmfa_compare #(.CNT_W(CNT_W), .NARROW_B(NARROW_B), .WIDE_B(WIDE_B)) u_cmp (
    .cnt_i(cnt_q), .data_i(act_data), .sel_i(act_sel),
    .coarse_hit(coarse_hit), .fine_hit(fine_hit),
    .range_ok(range_ok), .level(level)
  );

  assign rd_data_o = {host_data, host_sel, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)      pwm_o <= 1'b0;
    else if (tick_i) pwm_o <= level;
  end
endmodule

// File: rtl/pwmfa_channel_chk.sv
module pwmfa_channel_chk
  import pwmfa_pkg::*;
#(
  parameter int CNT_W = 14,
  localparam int REG_W = CNT_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             pwm_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             wrap,
  input logic [CNT_W-1:0] act_data,
  input carrier_e         act_sel,
  input logic             coarse_hit,
  input logic             fine_hit,
  input logic             range_ok
);
  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> rd_data_o[REG_W-1:1] == $past(wr_data_i[REG_W-1:1])); // R1
  AST_TICK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(pwm_o) && $stable(cnt_q)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R3
  AST_MAIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && range_ok && coarse_hit |=> pwm_o); // R5
  AST_FINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && range_ok && fine_hit |=> pwm_o); // R6
  AST_OUT_OF_RANGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !range_ok |=> !pwm_o); // R8
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_data) && $stable(act_sel)); // R9
endmodule

bind pwmfa_channel pwmfa_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .pwm_o(pwm_o),
  .cnt_q(cnt_q), .wrap(wrap), .act_data(act_data), .act_sel(act_sel),
  .coarse_hit(coarse_hit), .fine_hit(fine_hit), .range_ok(range_ok)
);

// File: tb/pwmfa_channel_test.sv
`timescale 1ns/1ps
module pwmfa_channel_test;
  localparam int W  = 10;
  localparam int RW = W + 2;
  localparam int P  = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [RW-1:0] wr_data_i = '0;
  logic [RW-1:0] rd_data_o;
  logic pwm_o;

  always #5 clk = ~clk;

  pwmfa_channel #(.CNT_W(W), .NARROW_B(6), .WIDE_B(8)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .pwm_o(pwm_o)
  );

  int checks = 0;
  int errors = 0;

  // bench model state
  int reg_m, act_d, act_s, cnt_m, per_d, per_s;
  bit exp_p, prev_pwm;
  int trace_err, rd_err, spread_err, hi_period, hi_base;
  int ticks_total, last_rise, last_gap;

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int bbits(int s);
    return (s != 0) ? 8 : 6;
  endfunction

  function automatic bit exp_level(int n, int d, int s);
    int fw = W - bbits(s);
    int L = 1 << bbits(s);
    int p = n % L;
    int q = n / L;
    int c = d >> fw;
    int f = d % (1 << fw);
    int r = 0;
    for (int k = 0; k < fw; k++) r = (r << 1) | ((q >> k) & 1);
    if (c == 0) return 1'b0;
    return (p < c) || (p == c && r < f);
  endfunction

  task automatic model_reset();
    reg_m = (1 << RW) - 1;
    act_d = P - 1; act_s = 1;
    per_d = P - 1; per_s = 1;
    cnt_m = 0; exp_p = 0; prev_pwm = 0;
    trace_err = 0; rd_err = 0; spread_err = 0; hi_period = 0; hi_base = 0;
    ticks_total = 0; last_rise = 0; last_gap = 0;
  endtask

  task automatic step(bit t, bit w, int d);
    int old_cnt, fw, L, c;
    bit period_end;
    tick_i = t; wr_en_i = w; wr_data_i = RW'(d);
    @(posedge clk);
    old_cnt = cnt_m;
    period_end = 0;
    if (t) begin
      exp_p = exp_level(cnt_m, act_d, act_s);
      if (cnt_m == P - 1) begin
        act_d = reg_m >> 2;
        act_s = (reg_m >> 1) & 1;
        period_end = 1;
      end
      cnt_m = (cnt_m + 1) % P;
    end
    if (w) reg_m = d | 1;
    @(negedge clk);
    if (pwm_o !== exp_p) trace_err++;
    if (rd_data_o !== RW'(reg_m)) rd_err++;
    if (t) begin
      ticks_total++;
      if (pwm_o && !prev_pwm) begin
        last_gap = ticks_total - last_rise;
        last_rise = ticks_total;
      end
      prev_pwm = pwm_o;
      hi_period += int'(pwm_o);
      hi_base += int'(pwm_o);
      fw = W - bbits(per_s);
      L = 1 << bbits(per_s);
      c = per_d >> fw;
      if (old_cnt % L == L - 1) begin
        if (c != 0 ? (hi_base != c && hi_base != c + 1) : (hi_base != 0)) spread_err++;
        hi_base = 0;
      end
      if (period_end) begin
        chk(trace_err == 0, "R5 R9 tick trace mismatches", trace_err, 0);
        chk(spread_err == 0, "R6 base cycle c/c+1 spread", spread_err, 0);
        chk(rd_err == 0, "R1 read-back mismatches", rd_err, 0);
        if (c != 0) chk(hi_period == per_d, "R7 period high ticks", hi_period, per_d);
        else        chk(hi_period == 0, "R8 illegal value period high ticks", hi_period, 0);
        trace_err = 0; spread_err = 0; rd_err = 0; hi_period = 0;
        per_d = act_d; per_s = act_s;
      end
    end
  endtask

  task automatic run(int n, int pct);
    for (int i = 0; i < n; i++) step(($urandom % 100) < pct, 1'b0, 0);
  endtask

  function automatic int mk(int d, int s);
    return (d << 2) | (s << 1) | 1;
  endfunction

  initial begin
    #1_900_000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    chk(rd_data_o == {RW{1'b1}}, "R2 reset register value", int'(rd_data_o), (1 << RW) - 1);
    chk(pwm_o == 1'b0, "R2 output low in reset", int'(pwm_o), 0);
    rst_n = 1'b1;
    // no ticks: nothing moves
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 0);
    chk(pwm_o == 1'b0 && trace_err == 0, "R3 frozen without tick", int'(pwm_o), 0);
    // first tick after reset: count 0 of all-ones value is high
    step(1'b1, 1'b0, 0);
    chk(pwm_o == 1'b1, "R2 R5 first tick from counter zero", int'(pwm_o), 1);

    // reserved bit ignores writes
    step(1'b1, 1'b1, mk(300, 0) & ~1);
    chk(rd_data_o == RW'(mk(300, 0)), "R1 reserved bit reads one", int'(rd_data_o), mk(300, 0));

    // narrow carrier, minimum legal, c=1 f=0: single-tick pulse each 64 ticks
    step(1'b1, 1'b1, mk(16, 0));
    run(2 * P + 20, 100);
    chk(last_gap == 64, "R4 narrow base cycle length", last_gap, 64);
    step(1'b1, 1'b1, mk(4, 1));
    run(2 * P + 20, 100);
    chk(last_gap == 256, "R4 wide base cycle length", last_gap, 256);

    // range edges and their neighbours
    step(1'b1, 1'b1, mk(15, 0));  run(2 * P + 7, 100);   // R8 below narrow edge
    step(1'b1, 1'b1, mk(3, 1));   run(2 * P + 7, 100);   // R8 below wide edge
    step(1'b1, 1'b1, mk(0, 0));   run(2 * P + 7, 100);   // R8 zero
    step(1'b1, 1'b1, mk(P - 1, 0)); run(2 * P + 7, 100); // R7 top, narrow
    step(1'b1, 1'b1, mk(P - 1, 1)); run(2 * P + 7, 100); // R7 top, wide
    step(1'b1, 1'b1, mk(17, 0));  run(2 * P + 7, 100);   // R6 one fine tick
    step(1'b1, 1'b1, mk(5, 1));   run(2 * P + 7, 100);   // R6 one fine tick, wide
    step(1'b1, 1'b1, mk(680, 1)); run(2 * P + 7, 100);   // R7 low bits zero

    // R9: second write in mid-period, ticks gated
    step(1'b1, 1'b1, mk(500, 0)); run(300, 60);
    step(1'b1, 1'b1, mk(77, 1));  run(2 * P + 300, 80);

    // random values and tick patterns
    for (int s = 0; s < 16; s++) begin
      int d = $urandom % P;
      int sl = $urandom % 2;
      int pct = 70 + ($urandom % 31);
      step(1'b1, 1'b1, mk(d, sl));
      run(P + ($urandom % P), pct);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule